// File: doc/BRIEF.md
# LRU Open-Row Bank Manager

This block sits in front of the command scheduler of a DRAM controller. For every request address, given as a bank and a row, it decides which row-management work must happen before the column access. The request may hit a row that is already open. It may need a fresh activate. Or it may need a precharge followed by an activate. The block keeps at most four banks with an open row, one row per bank. When a request names a bank that is not tracked and all entries are in use, it closes the row of the bank used least recently.

Requests arrive on a valid/ready handshake, and each accepted request yields one registered decision the next cycle. A hit is shown for a single cycle and needs no reply. An open or close-then-open decision is held until the scheduler acknowledges it, and no new request is taken meanwhile. A close-all input, pulsed before refresh, forgets every open row. A parameter selects a stricter policy in which only one bank may have an open row at a time.

Top module: `rowmgr_top`

## Requirements
- R1: A request whose bank is tracked with the same row yields decision kind 0 (hit). `dec_valid` is high for exactly one cycle and needs no acknowledgement.
- R2: A request whose bank is tracked with a different row yields kind 2 (close-then-open) with `pre_bank` equal to the request bank. The set of tracked banks does not change.
- R3: A request for an untracked bank while fewer than four banks are tracked yields kind 1 (open) and takes a free entry.
- R4: A request for an untracked bank while four banks are tracked yields kind 2, with `pre_bank` equal to the least recently used tracked bank. That bank is then replaced by the request bank.
- R5: Every accepted request makes its bank the most recently used, hits included.
- R6: The decision appears in the cycle after acceptance, with `act_bank`/`act_row` equal to the accepted bank and row.
- R7: While a kind 1 or kind 2 decision is waiting, `req_ready` is low and all decision outputs hold steady until the cycle after `dec_ack` is high. The next cycle then has `dec_valid` low.
- R8: While `close_all` is high, `req_ready` is low. Afterwards no bank is tracked, so a following request gets kind 1.
- R9: With `SINGLE_BANK`=1 only one bank is tracked. A request to any other bank yields kind 2 with `pre_bank` equal to the open bank.
- R10: After reset no bank is tracked, `dec_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| close_all | input | 1 | Forget all open rows (before refresh) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| dec_valid | output | 1 | Decision present |
| dec_kind | output | 2 | 0 hit, 1 open, 2 close-then-open |
| pre_bank | output | BANK_W | Bank to precharge (kind 2) |
| act_bank | output | BANK_W | Bank to activate / access |
| act_row | output | ROW_W | Row to activate / access |
| dec_ack | input | 1 | Scheduler accepts a kind 1 or 2 decision |

## Verification
A corrupted recency order would not show up at once. It appears only on the next eviction, as a wrong `pre_bank`, so the bench fills all entries, touches banks in a chosen order and then forces evictions. A lost or stale entry shows up on the next request to that bank: a hit comes out as an open or a close-then-open, or the reverse. Random traffic over a small set of banks and rows is compared request by request against a timestamp model, so any such error is seen within a few requests.

// File: rtl/rowmgr_pkg.sv
package rowmgr_pkg;
    typedef enum logic [1:0] {
        ACT_HIT  = 2'd0,
        ACT_OPEN = 2'd1,
        ACT_SWAP = 2'd2
    } row_act_e;

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/rowmgr_lookup.sv
module rowmgr_lookup #(
    parameter int DEPTH  = 4,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    localparam int IDX_W = rowmgr_pkg::idx_width(DEPTH)
) (
    input  logic              slot_v    [DEPTH],
    input  logic [BANK_W-1:0] slot_bank [DEPTH],
    input  logic [ROW_W-1:0]  slot_row  [DEPTH],
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              hit_any,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              row_same
);
    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        row_same = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit_any && slot_v[i] && slot_bank[i] == req_bank) begin
                hit_any  = 1'b1;
                hit_idx  = IDX_W'(i);
                row_same = (slot_row[i] == req_row);
            end
        end
    end
endmodule

// File: rtl/rowmgr_recency.sv
module rowmgr_recency #(
    parameter int DEPTH  = 4,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    localparam int IDX_W = rowmgr_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              upd,
    input  logic [IDX_W-1:0]  pos,
    input  logic [BANK_W-1:0] new_bank,
    input  logic [ROW_W-1:0]  new_row,
    output logic              slot_v    [DEPTH],
    output logic [BANK_W-1:0] slot_bank [DEPTH],
    output logic [ROW_W-1:0]  slot_row  [DEPTH]
);
    // Slot 0 is most recent; valid slots are always packed at the front.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    slot_v[i]    <= 1'b0;
                    slot_bank[i] <= '0;
                    slot_row[i]  <= '0;
                end else if (upd) begin
                    slot_v[i]    <= 1'b1;
                    slot_bank[i] <= new_bank;
                    slot_row[i]  <= new_row;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    slot_v[i]    <= 1'b0;
                    slot_bank[i] <= '0;
                    slot_row[i]  <= '0;
                end else if (upd && IDX_W'(i) <= pos) begin
                    slot_v[i]    <= slot_v[i-1];
                    slot_bank[i] <= slot_bank[i-1];
                    slot_row[i]  <= slot_row[i-1];
                end
            end
        end
    end
endmodule

// File: rtl/rowmgr_top.sv
module rowmgr_top #(
    parameter int BANK_W      = 3,
    parameter int ROW_W       = 14,
    parameter int OPEN_MAX    = 4,
    parameter bit SINGLE_BANK = 1'b0,
    localparam int DEPTH = SINGLE_BANK ? 1 : OPEN_MAX,
    localparam int IDX_W = rowmgr_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              dec_valid,
    output logic [1:0]        dec_kind,
    output logic [BANK_W-1:0] pre_bank,
    output logic [BANK_W-1:0] act_bank,
    output logic [ROW_W-1:0]  act_row,
    input  logic              dec_ack
);
    import rowmgr_pkg::*;

    logic              slot_v    [DEPTH];
    logic [BANK_W-1:0] slot_bank [DEPTH];
    logic [ROW_W-1:0]  slot_row  [DEPTH];
    logic              hit_any, row_same, accept, waiting;
    logic [IDX_W-1:0]  hit_idx, pos;
    row_act_e          kind_d, kind_q;
    logic [BANK_W-1:0] victim;

    rowmgr_lookup #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_lookup (
        .slot_v(slot_v), .slot_bank(slot_bank), .slot_row(slot_row),
        .req_bank(req_bank), .req_row(req_row),
        .hit_any(hit_any), .hit_idx(hit_idx), .row_same(row_same)
    );

    rowmgr_recency #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_recency (
        .clk(clk), .rst(rst), .flush(close_all), .upd(accept), .pos(pos),
        .new_bank(req_bank), .new_row(req_row),
        .slot_v(slot_v), .slot_bank(slot_bank), .slot_row(slot_row)
    );

    assign waiting   = dec_valid && (kind_q != ACT_HIT);
    assign req_ready = !close_all && !waiting;
    assign accept    = req_valid && req_ready;
    assign pos       = hit_any ? hit_idx : IDX_W'(DEPTH - 1);

    always_comb begin
        if (hit_any) begin
            kind_d = row_same ? ACT_HIT : ACT_SWAP;
            victim = req_bank;
        end else begin
            kind_d = slot_v[DEPTH-1] ? ACT_SWAP : ACT_OPEN;
            victim = slot_bank[DEPTH-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            kind_q    <= ACT_HIT;
            pre_bank  <= '0;
            act_bank  <= '0;
            act_row   <= '0;
        end else if (accept) begin
            dec_valid <= 1'b1;
            kind_q    <= kind_d;
            pre_bank  <= victim;
            act_bank  <= req_bank;
            act_row   <= req_row;
        end else if (dec_valid && (kind_q == ACT_HIT || dec_ack)) begin
            dec_valid <= 1'b0;
        end
    end

    assign dec_kind = kind_q;
endmodule

// File: rtl/rowmgr_checker.sv
module rowmgr_checker #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              close_all,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BANK_W-1:0] req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic              dec_valid,
    input logic [1:0]        dec_kind,
    input logic [BANK_W-1:0] pre_bank,
    input logic [BANK_W-1:0] act_bank,
    input logic [ROW_W-1:0]  act_row,
    input logic              dec_ack
);
    assert_wait_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind != 2'd0) |-> !req_ready);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind != 2'd0 && !dec_ack) |=>
        (dec_valid && $stable(dec_kind) && $stable(pre_bank)
         && $stable(act_bank) && $stable(act_row)));

    assert_hit_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind == 2'd0 && !(req_valid && req_ready)) |=> !dec_valid);

    assert_kind_legal_R1: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_kind != 2'd3);

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
        (dec_valid && act_bank == $past(req_bank) && act_row == $past(req_row)));

    assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
        close_all |-> !req_ready);
endmodule

bind rowmgr_top rowmgr_checker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .close_all(close_all), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .pre_bank(pre_bank),
    .act_bank(act_bank), .act_row(act_row), .dec_ack(dec_ack)
);

// File: tb/rowmgr_top_test.sv
module rowmgr_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic close_all = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic rdy [2];
    logic dv [2];
    logic [1:0] dk [2];
    logic [2:0] pb [2];
    logic [2:0] ab [2];
    logic [13:0] ar [2];
    logic ack [2];

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model: timestamped entries
    logic        mv [2][4];
    logic [2:0]  mb [2][4];
    logic [13:0] mr [2][4];
    int          ms [2][4];
    int          stamp = 0;

    always #2 clk = ~clk;

    rowmgr_top uut (
        .clk(clk), .rst(rst), .close_all(close_all), .req_valid(req_valid),
        .req_ready(rdy[0]), .req_bank(req_bank), .req_row(req_row),
        .dec_valid(dv[0]), .dec_kind(dk[0]), .pre_bank(pb[0]),
        .act_bank(ab[0]), .act_row(ar[0]), .dec_ack(ack[0])
    );

    rowmgr_top #(.SINGLE_BANK(1'b1)) uut_one (
        .clk(clk), .rst(rst), .close_all(close_all), .req_valid(req_valid),
        .req_ready(rdy[1]), .req_bank(req_bank), .req_row(req_row),
        .dec_valid(dv[1]), .dec_kind(dk[1]), .pre_bank(pb[1]),
        .act_bank(ab[1]), .act_row(ar[1]), .dec_ack(ack[1])
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 4; i++) mv[d][i] = 1'b0;
    endtask

    // cat: 0 hit, 1 open, 2 row miss, 3 eviction
    task automatic model_step(input int d, input logic [2:0] b, input logic [13:0] r,
                              output int cat, output int epre);
        int depth = (d == 0) ? 4 : 1;
        int j = -1;
        int cnt = 0;
        int vic = 0;
        stamp++;
        epre = 0;
        for (int i = 0; i < depth; i++) if (mv[d][i] && mb[d][i] == b) j = i;
        if (j >= 0) begin
            cat = (mr[d][j] == r) ? 0 : 2;
            epre = b;
        end else begin
            for (int i = 0; i < depth; i++) if (mv[d][i]) cnt++;
            if (cnt < depth) begin
                cat = 1;
                for (int i = depth - 1; i >= 0; i--) if (!mv[d][i]) j = i;
            end else begin
                cat = 3;
                for (int i = 1; i < depth; i++) if (ms[d][i] < ms[d][vic]) vic = i;
                j = vic;
                epre = mb[d][vic];
            end
        end
        mv[d][j] = 1'b1; mb[d][j] = b; mr[d][j] = r; ms[d][j] = stamp;
    endtask

    task automatic judge(input int d, input int cat, input int epre,
                         input logic [2:0] b, input logic [13:0] r);
        string tag;
        int ek = (cat == 3) ? 2 : cat;
        if (d == 1) tag = "R9";
        else if (cat == 0) tag = "R1";
        else if (cat == 1) tag = "R3";
        else if (cat == 2) tag = "R2";
        else tag = "R4";
        check(dv[d] == 1'b1, "R6 dec_valid", dv[d], 1);
        check(dk[d] == 2'(ek), tag, dk[d], ek);
        if (ek == 2) check(pb[d] == epre, {tag, " pre_bank"}, pb[d], epre);
        check(ab[d] == b && ar[d] == r, "R6 act address", ar[d], r);
        if (ek != 0) check(rdy[d] == 1'b0, "R7 ready low", rdy[d], 0);
    endtask

    task automatic send(input logic [2:0] b, input logic [13:0] r, output int pre0);
        int cat, epre;
        @(negedge clk);
        req_valid = 1'b1; req_bank = b; req_row = r;
        @(negedge clk);
        req_valid = 1'b0;
        for (int d = 0; d < 2; d++) begin
            model_step(d, b, r, cat, epre);
            judge(d, cat, epre, b, r);
            ack[d] = (dk[d] != 2'd0);
        end
        pre0 = pb[0];
        @(negedge clk);
        ack[0] = 1'b0; ack[1] = 1'b0;
        for (int d = 0; d < 2; d++) begin
            check(dv[d] == 1'b0, "R7 decision retired", dv[d], 0);
            check(rdy[d] == 1'b1, "R7 ready back", rdy[d], 1);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p, cat, epre;
        logic [1:0] k0;
        void'($urandom(32'd2024));
        ack[0] = 1'b0; ack[1] = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(dv[d] == 1'b0, "R10 dec_valid", dv[d], 0);
            check(rdy[d] == 1'b1, "R10 ready", rdy[d], 1);
        end

        // fill four banks, then a hit on bank 0, row miss on bank 2
        send(3'd0, 14'd10, p);
        send(3'd1, 14'd11, p);
        send(3'd2, 14'd12, p);
        send(3'd3, 14'd13, p);
        send(3'd0, 14'd10, p);
        send(3'd2, 14'd99, p);
        // R5: bank 0 was touched by a hit, so bank 1 is the oldest
        send(3'd4, 14'd20, p);
        check(p == 1, "R5 eviction skips recently hit bank", p, 1);
        send(3'd5, 14'd21, p);
        check(p == 3, "R5 second eviction", p, 3);

        // R8: close-all
        @(negedge clk);
        close_all = 1'b1;
        #0;
        check(rdy[0] == 1'b0 && rdy[1] == 1'b0, "R8 ready low in close_all", rdy[0], 0);
        @(negedge clk);
        close_all = 1'b0;
        model_clear();

        // R7: pending decision held without ack, competing request ignored
        @(negedge clk);
        req_valid = 1'b1; req_bank = 3'd5; req_row = 14'd9;
        @(negedge clk);
        req_bank = 3'd6; req_row = 14'd1;
        for (int d = 0; d < 2; d++) begin
            model_step(d, 3'd5, 14'd9, cat, epre);
            judge(d, cat, epre, 3'd5, 14'd9);
            check(dk[d] == 2'd1, "R8 open after close_all", dk[d], 1);
        end
        k0 = dk[0];
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin
                check(dv[d] == 1'b1 && rdy[d] == 1'b0, "R7 held", dv[d], 1);
                check(ab[d] == 3'd5 && ar[d] == 14'd9, "R7 stable address", ar[d], 9);
            end
            check(dk[0] == k0, "R7 stable kind", dk[0], k0);
        end
        req_valid = 1'b0;
        ack[0] = 1'b1; ack[1] = 1'b1;
        @(negedge clk);
        ack[0] = 1'b0; ack[1] = 1'b0;
        check(dv[0] == 1'b0 && dv[1] == 1'b0, "R7 retire after ack", dv[0], 0);
        send(3'd5, 14'd9, p);   // hit proves bank 6 was never taken
        send(3'd6, 14'd1, p);

        // random traffic over few banks and rows
        for (int n = 0; n < 400; n++)
            send(3'($urandom % 7), 14'($urandom % 3), p);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule